// File: doc/BRIEF.md
# Fixed-Point Narrowing Quantizer

This block reduces a signed two's-complement fixed-point sample to a short signed format. The input word has 24 bits, 4 of them integer bits (sign included) and 20 fraction bits. The output word has 8 bits, 1 integer bit (the sign) and 7 fraction bits. It therefore spans -1.0 up to 1.0 - 2^-7.

The 13 low fraction bits that the output cannot hold are removed under one of three rounding policies. The rounded value is then fitted into 8 bits under one of three overflow policies. The two policy selectors ride with each input beat, so a stream can change policy from one sample to the next.

Samples enter and leave on valid/ready streams:
- An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- The result is held in the output register, with `out_valid` high, until the edge on which `out_ready` is high.
- `in_ready` is high while the output register is empty or is being drained in the same cycle, so a full-rate stream passes with no bubbles.
- A consumer that holds `out_ready` low stalls the producer, and no beat is lost or overwritten.

Two sticky flags collect, over all accepted beats, whether any beat lost nonzero low bits and whether any beat fell out of range. They return to zero only on reset or on `flag_clear`.

Top module: `fixq_convert`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid`, `out_data`, `flag_inexact` and `flag_range` all become 0. After reset, `in_ready` is 1.
- R2: A rounding select of 0 rounds to the nearest output step. A discarded part of exactly one half step rounds upward (toward plus infinity), and less than half rounds down.
- R3: A rounding select of 1 rounds toward zero. A negative input with a nonzero discarded part moves up by one output step; a positive input is truncated.
- R4: A rounding select of 2 or 3 drops the discarded bits, which rounds toward minus infinity for both signs.
- R5: Rounding happens before the range test. A value that rounds up past +127 output steps is out of range, even though its truncated value is in range.
- R6: An overflow select of 0 replaces an out-of-range result with 0x7F when it is too positive and with 0x80 when it is too negative.
- R7: An overflow select of 1 replaces an out-of-range result with 0x00. In-range results, including exactly -1.0 (0x80), pass unchanged.
- R8: An overflow select of 2 or 3 outputs the low 8 bits of the rounded two's-complement value.
- R9: A beat accepted on one edge appears on `out_data`, with `out_valid` high, after that edge. `out_valid` stays high until a cycle in which `out_ready` is high and no new beat is accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` holds its value.
- R11: An accepted beat with any nonzero discarded bit sets `flag_inexact`. An accepted beat whose rounded value lies outside -128..+127 output steps sets `flag_range`. Both flags hold until reset, or until a cycle with `flag_clear` high, which clears them and takes priority over a setting beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 24 | Signed input, 4 integer and 20 fraction bits |
| in_rnd_sel | input | 2 | Rounding select: 0 nearest (ties up), 1 toward zero, 2/3 drop bits |
| in_ovf_sel | input | 2 | Overflow select: 0 clamp, 1 zero, 2/3 wrap |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 8 | Signed result, 1 integer and 7 fraction bits |
| flag_clear | input | 1 | Clears both sticky flags |
| flag_inexact | output | 1 | Sticky: some accepted beat lost nonzero bits |
| flag_range | output | 1 | Sticky: some accepted beat was out of range |

## Verification
The bench drives positive and negative exact half-step ties. A design that rounds ties away from zero, or rounds them to even, gives the wrong code on one of the two signs. Negative inputs with a small discarded part expose a design that treats dropping the low bits as rounding toward zero, or the reverse; that design is off by one step. A value just below +1.0 that rounds up exposes a design that tests the range before rounding: it would emit 0x80 or leave the range flag clear. Stalls with new beats offered catch a design that overwrites the held result. Clears that coincide with a setting beat catch a design that gives the set priority.

// File: rtl/fixq_pkg.sv
package fixq_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_TOZERO  = 2'd1,
    RND_FLOOR   = 2'd2
  } rnd_pol_e;

  typedef enum logic [1:0] {
    OVF_CLAMP = 2'd0,
    OVF_ZERO  = 2'd1,
    OVF_WRAP  = 2'd2
  } ovf_pol_e;

  // Code 3 folds onto the last policy in each field.
  function automatic rnd_pol_e decode_rnd(input logic [1:0] code);
    case (code)
      2'd0:    decode_rnd = RND_NEAREST;
      2'd1:    decode_rnd = RND_TOZERO;
      default: decode_rnd = RND_FLOOR;
    endcase
  endfunction

  function automatic ovf_pol_e decode_ovf(input logic [1:0] code);
    case (code)
      2'd0:    decode_ovf = OVF_CLAMP;
      2'd1:    decode_ovf = OVF_ZERO;
      default: decode_ovf = OVF_WRAP;
    endcase
  endfunction

endpackage

// File: rtl/fixq_round.sv
module fixq_round
  import fixq_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int SHIFT = 13,
  localparam int KW   = IN_W - SHIFT,
  localparam int RW   = KW + 1
) (
  input  logic [IN_W-1:0] din,
  input  rnd_pol_e        pol,
  output logic [RW-1:0]   rounded,
  output logic            inexact
);

  logic [KW-1:0]    kept;
  logic [SHIFT-1:0] disc;
  logic             half;
  logic             bump;

  assign kept    = din[IN_W-1:SHIFT];
  assign disc    = din[SHIFT-1:0];
  assign half    = disc[SHIFT-1];
  assign inexact = |disc;

  always_comb begin
    case (pol)
      RND_NEAREST: bump = half;
      RND_TOZERO:  bump = din[IN_W-1] & inexact;
      default:     bump = 1'b0;
    endcase
  end

  // One extra bit so that kept + 1 can never wrap.
  assign rounded = {kept[KW-1], kept} + {{(RW-1){1'b0}}, bump};

endmodule

// File: rtl/fixq_range.sv
module fixq_range
  import fixq_pkg::*;
#(
  parameter int RW    = 12,
  parameter int OUT_W = 8,
  localparam int HW   = RW - OUT_W + 1
) (
  input  logic [RW-1:0]    rounded,
  input  ovf_pol_e         pol,
  output logic [OUT_W-1:0] result,
  output logic             out_of_range
);

  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic [HW-1:0] head;
  logic          neg;

  // In range only when the bits from the output sign upward agree.
  assign head         = rounded[RW-1:OUT_W-1];
  assign neg          = rounded[RW-1];
  assign out_of_range = !((&head) || !(|head));

  always_comb begin
    result = rounded[OUT_W-1:0];
    if (out_of_range) begin
      case (pol)
        OVF_CLAMP: result = neg ? MIN_CODE : MAX_CODE;
        OVF_ZERO:  result = '0;
        default:   result = rounded[OUT_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/fixq_stage.sv
module fixq_stage #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [OUT_W-1:0] s_result,
  input  logic             s_inexact,
  input  logic             s_range,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_data,
  input  logic             clr,
  output logic             sticky_inexact,
  output logic             sticky_range
);

  logic take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_data  <= s_result;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sticky_inexact <= 1'b0;
      sticky_range   <= 1'b0;
    end else if (take) begin
      sticky_inexact <= sticky_inexact | s_inexact;
      sticky_range   <= sticky_range | s_range;
    end
  end

endmodule

// File: rtl/fixq_convert.sv
module fixq_convert
  import fixq_pkg::*;
#(
  parameter int IN_W     = 24,
  parameter int IN_FRAC  = 20,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 7,
  localparam int SHIFT   = IN_FRAC - OUT_FRAC,
  localparam int RW      = IN_W - SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_rnd_sel,
  input  logic [1:0]       in_ovf_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  input  logic             flag_clear,
  output logic             flag_inexact,
  output logic             flag_range
);

  logic [RW-1:0]    rounded;
  logic             lost_bits;
  logic [OUT_W-1:0] fitted;
  logic             oor;

  fixq_round #(.IN_W(IN_W), .SHIFT(SHIFT)) u_round (
    .din     (in_data),
    .pol     (decode_rnd(in_rnd_sel)),
    .rounded (rounded),
    .inexact (lost_bits)
  );

  fixq_range #(.RW(RW), .OUT_W(OUT_W)) u_range (
    .rounded      (rounded),
    .pol          (decode_ovf(in_ovf_sel)),
    .result       (fitted),
    .out_of_range (oor)
  );

  fixq_stage #(.OUT_W(OUT_W)) u_stage (
    .clk            (clk),
    .rst            (rst),
    .s_valid        (in_valid),
    .s_ready        (in_ready),
    .s_result       (fitted),
    .s_inexact      (lost_bits),
    .s_range        (oor),
    .m_valid        (out_valid),
    .m_ready        (out_ready),
    .m_data         (out_data),
    .clr            (flag_clear),
    .sticky_inexact (flag_inexact),
    .sticky_range   (flag_range)
  );

endmodule

// File: rtl/fixq_convert_chk.sv
module fixq_convert_chk #(
  parameter int IN_W    = 24,
  parameter int IN_FRAC = 20,
  parameter int OUT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic [1:0]       in_ovf_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             flag_clear,
  input logic             flag_inexact,
  input logic             flag_range
);

  logic take;
  logic big_pos;

  assign take    = in_valid && in_ready;
  // Non-negative input with an integer part of at least one: always above range.
  assign big_pos = !in_data[IN_W-1] && (|in_data[IN_W-2:IN_FRAC]);

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_clamp_high_R6: assert property (@(posedge clk) disable iff (rst)
    take && in_ovf_sel == 2'd0 && big_pos |=> out_data == {1'b0, {(OUT_W-1){1'b1}}});

  assert_zero_on_range_R7: assert property (@(posedge clk) disable iff (rst)
    take && in_ovf_sel == 2'd1 && big_pos |=> out_data == '0);

  assert_sticky_keep_R11: assert property (@(posedge clk) disable iff (rst)
    flag_range && !flag_clear |=> flag_range);

  assert_sticky_keep_inexact_R11: assert property (@(posedge clk) disable iff (rst)
    flag_inexact && !flag_clear |=> flag_inexact);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    flag_clear |=> !flag_inexact && !flag_range);

endmodule

bind fixq_convert fixq_convert_chk #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .in_ovf_sel   (in_ovf_sel),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .flag_clear   (flag_clear),
  .flag_inexact (flag_inexact),
  .flag_range   (flag_range)
);

// File: tb/fixq_convert_tb.sv
`timescale 1ns/1ps
module fixq_convert_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic [1:0]  in_rnd_sel = '0;
  logic [1:0]  in_ovf_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        flag_clear = 1'b0;
  logic        flag_inexact;
  logic        flag_range;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fixq_convert dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rnd_sel(in_rnd_sel), .in_ovf_sel(in_ovf_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .flag_clear(flag_clear), .flag_inexact(flag_inexact), .flag_range(flag_range)
  );

  // Behavioural reference: integer arithmetic on the numeric value.
  function automatic void quant(input int x, input int rm, input int om,
                                output int res, output bit inex, output bit ov);
    int fl, disc, r;
    fl   = x >>> 13;
    disc = x & 8191;
    inex = (disc != 0);
    if (rm == 0)      r = fl + ((disc >= 4096) ? 1 : 0);
    else if (rm == 1) r = fl + ((x < 0 && disc != 0) ? 1 : 0);
    else              r = fl;
    ov = (r > 127) || (r < -128);
    if (!ov)          res = r & 255;
    else if (om == 0) res = (r > 0) ? 127 : 128;
    else if (om == 1) res = 0;
    else              res = r & 255;
  endfunction

  bit mv, fi, fo;
  int md;

  always @(posedge clk) begin
    int  res;
    bit  inx, ov, acc;
    quant(int'($signed(in_data)), int'(in_rnd_sel), int'(in_ovf_sel), res, inx, ov);
    if (rst) begin
      mv = 0; md = 0; fi = 0; fo = 0;
    end else begin
      acc = in_valid && (!mv || out_ready);
      if (flag_clear) begin fi = 0; fo = 0; end
      else if (acc)   begin fi = fi | inx; fo = fo | ov; end
      if (acc)            begin mv = 1; md = res; end
      else if (out_ready) mv = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    check(out_valid == mv, "R9 out_valid vs model", int'(out_valid), int'(mv));
    if (mv) check(int'(out_data) == md, "R9 out_data vs model", int'(out_data), md);
    check(in_ready == (!mv || out_ready), "R10 in_ready vs model", int'(in_ready), int'(!mv || out_ready));
    check(flag_inexact == fi, "R11 flag_inexact vs model", int'(flag_inexact), int'(fi));
    check(flag_range == fo, "R11 flag_range vs model", int'(flag_range), int'(fo));
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) model_cmp();
  endtask

  task automatic beat(input int x, input int rm, input int om, input int exp, input string tag);
    in_data = x[23:0]; in_rnd_sel = rm[1:0]; in_ovf_sel = om[1:0];
    in_valid = 1'b1; out_ready = 1'b1;
    tick();
    check(out_valid && int'(out_data) == exp, tag, int'(out_data), exp);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 reset state
    check(!out_valid && out_data == 8'h00, "R1 outputs after reset", int'(out_data), 0);
    check(!flag_inexact && !flag_range, "R1 flags after reset", int'({flag_inexact, flag_range}), 0);
    check(in_ready, "R1 ready after reset", int'(in_ready), 1);

    // Rounding policies: +5.5, -5.5 and -5.61 output steps
    beat(45056, 0, 0, 8'h06, "R2 positive tie rounds up");
    beat(45056, 1, 0, 8'h05, "R3 positive toward zero");
    beat(45056, 2, 0, 8'h05, "R4 drop bits positive");
    beat(45056, 3, 0, 8'h05, "R4 rounding code 3 acts as 2");
    beat(-45056, 0, 0, 8'hFB, "R2 negative tie rounds up");
    beat(-45056, 1, 0, 8'hFB, "R3 negative toward zero");
    beat(-45056, 2, 0, 8'hFA, "R4 drop bits negative floors");
    beat(-45960, 0, 0, 8'hFA, "R2 below half rounds down");
    beat(-45960, 1, 0, 8'hFB, "R3 negative inexact moves up");
    beat(-45960, 3, 0, 8'hFA, "R4 code 3 floors negative");

    // Round-then-range: 127.5 steps
    beat(1044480, 0, 0, 8'h7F, "R5 rounding overflow clamps");
    beat(1044480, 0, 1, 8'h00, "R5 rounding overflow zeroes");
    beat(1044480, 0, 2, 8'h80, "R5 rounding overflow wraps");
    beat(1044480, 2, 1, 8'h7F, "R5 truncated stays in range");

    // Overflow policies
    beat(8388607, 0, 0, 8'h7F, "R6 max input clamps high");
    beat(-8388608, 0, 0, 8'h80, "R6 min input clamps low");
    beat(1638400, 2, 1, 8'h00, "R7 out of range gives zero");
    beat(-1048576, 2, 1, 8'h80, "R7 exact -1.0 passes");
    beat(1638400, 2, 2, 8'hC8, "R8 wrap positive");
    beat(1638400, 2, 3, 8'hC8, "R8 overflow code 3 wraps");
    beat(-1638400, 2, 2, 8'h38, "R8 wrap negative");

    // Sticky flags
    flag_clear = 1'b1; tick(); flag_clear = 1'b0;
    check(!flag_inexact && !flag_range, "R11 clear", int'({flag_inexact, flag_range}), 0);
    beat(8192, 2, 0, 8'h01, "R11 exact beat data");
    check(!flag_inexact, "R11 exact leaves inexact clear", int'(flag_inexact), 0);
    beat(100, 2, 0, 8'h00, "R11 inexact beat data");
    check(flag_inexact, "R11 inexact set", int'(flag_inexact), 1);
    beat(8192, 2, 0, 8'h01, "R11 exact after inexact");
    check(flag_inexact && !flag_range, "R11 inexact holds", int'({flag_inexact, flag_range}), 2);
    beat(1638400, 2, 0, 8'h7F, "R11 range beat data");
    beat(8192, 2, 0, 8'h01, "R11 in range after range");
    check(flag_range, "R11 range holds", int'(flag_range), 1);
    in_data = 24'd1638400; in_valid = 1'b1; flag_clear = 1'b1;
    tick();
    in_valid = 1'b0; flag_clear = 1'b0;
    check(!flag_inexact && !flag_range, "R11 clear beats set", int'({flag_inexact, flag_range}), 0);

    // Back-pressure
    tick();
    out_ready = 1'b0; in_data = 24'd8192; in_rnd_sel = 2'd2; in_ovf_sel = 2'd0; in_valid = 1'b1;
    tick();
    in_data = 24'd16384;
    check(out_valid && out_data == 8'h01 && !in_ready, "R10 stalled holds first", int'(out_data), 1);
    tick(); tick();
    check(out_data == 8'h01 && !in_ready, "R10 still stalled", int'(out_data), 1);
    out_ready = 1'b1;
    tick();
    check(out_valid && out_data == 8'h02, "R9 next beat after drain", int'(out_data), 2);
    in_valid = 1'b0;
    tick();
    check(!out_valid, "R9 valid drops after drain", int'(out_valid), 0);

    // Mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int sel = int'($urandom_range(0, 3));
      if (sel == 0)      in_data = 24'($urandom_range(0, 2097151) - 1048576);
      else if (sel == 1) in_data = 24'(int'($urandom_range(0, 255)) * 8192 + (($urandom_range(0, 1) == 1) ? 4096 : 0) - 1048576);
      else               in_data = 24'($urandom);
      in_rnd_sel = 2'($urandom_range(0, 3));
      in_ovf_sel = 2'($urandom_range(0, 3));
      in_valid   = ($urandom_range(0, 3) != 0);
      out_ready  = ($urandom_range(0, 3) != 0);
      flag_clear = ($urandom_range(0, 31) == 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule